// File: doc/BRIEF.md
# Programmable Parallel Interface Adapter

This block is a memory-mapped parallel I/O peripheral with two identical 8-bit sides, A and B. Each side has three registers. The direction register sets each port line as an input or an output. The output register holds the value that output lines drive. The control register holds the configuration and two event flags. Each side also has two control lines. Control line 1 is an edge-sensitive input that raises an event flag and, when enabled, the side's interrupt. Control line 2 can be set up as a second edge input, as a steady output level, or as an automatic active-low "data present" strobe that follows each write to the output register.

A host reaches the registers over a simple synchronous bus, using chip select, a two-bit register select, read and write strobes and 8-bit data. The data and direction registers of a side share one address, and a control-register bit chooses which of the two an access reaches. A read of the data register returns the port as the peripheral sees it and clears that side's flags and interrupt. This makes it possible to wait for an event, collect a byte and re-arm in a single access. Each port is given as separate input, output and output-enable vectors, so pads stay outside the block.

Top module: `par_io_adapter`

## Requirements
- R1: After reset all registers read 0x00, every port output enable and control-line-2 output enable is 0, and both interrupts are low.
- R2: Each port bit is an output (its output-enable bit is 1) exactly when the matching direction-register bit is 1, and is an input when that bit is 0.
- R3: Register select 0 and 2 reach side A and side B data storage, and 1 and 3 reach the A and B control registers. At select 0 or 2, control bit 2 = 0 targets the direction register and bit 2 = 1 targets the output register. Port outputs always drive the output register value.
- R4: A data-register read returns the pin value on input bits and the output register value on output bits.
- R5: Control line 1 passes through two synchronizer flops. An active edge sets control bit 7, where control bit 1 = 1 selects rising and 0 selects falling. The opposite edge has no effect. The flag appears in the third clock after the input change.
- R6: The interrupt is high when bit 7 is set and control bit 0 is 1. A masked flag still reads back as 1 and raises the interrupt once the enable is written.
- R7: A data-register read (control bit 2 = 1) clears control bits 7 and 6 and drops the interrupt. A direction-register read or a control write leaves the flags unchanged.
- R8: Control bits 7 and 6 are read-only, and a control write updates only bits 5..0.
- R9: With control bits 5..4 = 10, control line 2 is an output that idles high and goes low for exactly one clock after each write to the output register. A write to the direction register gives no pulse.
- R10: With control bits 5..4 = 11, control line 2 is an output that drives control bit 3 steadily.
- R11: With control bit 5 = 0, control line 2 is an input (output enable 0). Its edge, rising when bit 4 = 1 and falling when bit 4 = 0, sets control bit 6, and that flag raises the interrupt when bit 3 = 1.
- R12: The two sides are independent, so an event or access on one side changes neither the flags nor the interrupt of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| rsel_i | input | 2 | Register select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (0 when not reading) |
| irq_a_o | output | 1 | Side A interrupt |
| irq_b_o | output | 1 | Side B interrupt |
| port_a_i | input | 8 | Side A pin values |
| port_a_o | output | 8 | Side A output values |
| port_a_oe_o | output | 8 | Side A output enables |
| ctl1_a_i | input | 1 | Side A control line 1 input |
| ctl2_a_i | input | 1 | Side A control line 2 input |
| ctl2_a_o | output | 1 | Side A control line 2 output |
| ctl2_a_oe_o | output | 1 | Side A control line 2 output enable |
| port_b_i | input | 8 | Side B pin values |
| port_b_o | output | 8 | Side B output values |
| port_b_oe_o | output | 8 | Side B output enables |
| ctl1_b_i | input | 1 | Side B control line 1 input |
| ctl2_b_i | input | 1 | Side B control line 2 input |
| ctl2_b_o | output | 1 | Side B control line 2 output |
| ctl2_b_oe_o | output | 1 | Side B control line 2 output enable |

## Verification
Side A is set up for enabled rising edges (0xC7) and side B for enabled falling edges with a strobe (0xED). Each side then gets its active edge and the opposite edge, which separates a correct edge select from a block that reacts to any transition. A direction of 0xF0 with pins 0x33 and an output value of 0x5A gives a read of 0x53 that no pure-pin or pure-register read matches. Setting a flag while masked and then enabling it shows that flag and enable are separate. Writes to the data register are compared with writes to the direction register, and reads of the data register with reads of the direction register, to confirm that only the data target pulses the strobe or clears the flags. The level and input modes of control line 2 are each tried with both polarities.

// File: rtl/par_io_pkg.sv
package par_io_pkg;
  localparam int unsigned DATA_W = 8;

  // Control register bit positions
  localparam int unsigned CR_C1_EN   = 0;
  localparam int unsigned CR_C1_RISE = 1;
  localparam int unsigned CR_DSEL    = 2;
  localparam int unsigned CR_C2_B3   = 3;
  localparam int unsigned CR_C2_B4   = 4;
  localparam int unsigned CR_C2_OUT  = 5;
  localparam int unsigned CR_FLAG2   = 6;
  localparam int unsigned CR_FLAG1   = 7;
  localparam int unsigned CR_CFG_W   = 6;

  typedef enum logic [1:0] {
    C2_INPUT  = 2'd0,
    C2_STROBE = 2'd1,
    C2_LEVEL  = 2'd2
  } c2_mode_e;

  function automatic c2_mode_e c2_decode(input logic [DATA_W-1:0] cr);
    if (!cr[CR_C2_OUT])    return C2_INPUT;
    else if (cr[CR_C2_B4]) return C2_LEVEL;
    else                   return C2_STROBE;
  endfunction
endpackage

// File: rtl/par_io_edge.sv
module par_io_edge #(
  parameter int unsigned STAGES = 2  // must be >= 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
  assign fall_o = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/par_io_side.sv
module par_io_side
  import par_io_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_dat_i,
  input  logic              wr_ctl_i,
  input  logic              rd_dat_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] dat_view_o,
  output logic [DATA_W-1:0] ctl_view_o,
  input  logic [DATA_W-1:0] pin_i,
  output logic [DATA_W-1:0] pin_o,
  output logic [DATA_W-1:0] pin_oe_o,
  input  logic              c1_i,
  input  logic              c2_i,
  output logic              c2_o,
  output logic              c2_oe_o,
  output logic              irq_o,
  output logic              flag_set_o
);
  logic [DATA_W-1:0]   ddr_q, out_q;
  logic [CR_CFG_W-1:0] cfg_q;
  logic                flag1_q, flag2_q, strobe_q;
  logic                c1_rise, c1_fall, c2_rise, c2_fall;
  logic                set1, set2, clr;
  logic [DATA_W-1:0]   cr;
  c2_mode_e            mode;

  par_io_edge #(.STAGES(SYNC_STAGES)) u_c1 (
    .clk_i, .rst_ni, .pin_i(c1_i), .rise_o(c1_rise), .fall_o(c1_fall)
  );
  par_io_edge #(.STAGES(SYNC_STAGES)) u_c2 (
    .clk_i, .rst_ni, .pin_i(c2_i), .rise_o(c2_rise), .fall_o(c2_fall)
  );

  assign cr   = {flag1_q, flag2_q, cfg_q};
  assign mode = c2_decode(cr);

  always_comb begin
    set1 = cr[CR_C1_RISE] ? c1_rise : c1_fall;
    set2 = (mode == C2_INPUT) && (cr[CR_C2_B4] ? c2_rise : c2_fall);
    clr  = rd_dat_i && cr[CR_DSEL];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ddr_q    <= '0;
      out_q    <= '0;
      cfg_q    <= '0;
      flag1_q  <= 1'b0;
      flag2_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      if (wr_ctl_i) cfg_q <= wdata_i[CR_CFG_W-1:0];
      if (wr_dat_i) begin
        if (cr[CR_DSEL]) out_q <= wdata_i;
        else             ddr_q <= wdata_i;
      end
      // a new edge wins over a simultaneous clearing read
      flag1_q  <= set1 | (flag1_q & ~clr);
      flag2_q  <= set2 | (flag2_q & ~clr);
      strobe_q <= wr_dat_i && cr[CR_DSEL] && (mode == C2_STROBE);
    end
  end

  always_comb begin
    dat_view_o = cr[CR_DSEL] ? ((pin_i & ~ddr_q) | (out_q & ddr_q)) : ddr_q;
    ctl_view_o = cr;
    pin_o      = out_q;
    pin_oe_o   = ddr_q;
    irq_o      = (flag1_q && cr[CR_C1_EN]) ||
                 (flag2_q && cr[CR_C2_B3] && (mode == C2_INPUT));
    flag_set_o = set1 | set2;
    unique case (mode)
      C2_STROBE: c2_o = ~strobe_q;
      C2_LEVEL:  c2_o = cr[CR_C2_B3];
      default:   c2_o = 1'b0;
    endcase
    c2_oe_o = (mode != C2_INPUT);
  end
endmodule

// File: rtl/par_io_adapter.sv
module par_io_adapter
  import par_io_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic [1:0]        rsel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_a_o,
  output logic              irq_b_o,
  input  logic [DATA_W-1:0] port_a_i,
  output logic [DATA_W-1:0] port_a_o,
  output logic [DATA_W-1:0] port_a_oe_o,
  input  logic              ctl1_a_i,
  input  logic              ctl2_a_i,
  output logic              ctl2_a_o,
  output logic              ctl2_a_oe_o,
  input  logic [DATA_W-1:0] port_b_i,
  output logic [DATA_W-1:0] port_b_o,
  output logic [DATA_W-1:0] port_b_oe_o,
  input  logic              ctl1_b_i,
  input  logic              ctl2_b_i,
  output logic              ctl2_b_o,
  output logic              ctl2_b_oe_o
);
  localparam int unsigned SIDES = 2;

  logic [DATA_W-1:0] pin_in  [SIDES];
  logic [DATA_W-1:0] pin_out [SIDES];
  logic [DATA_W-1:0] pin_oe  [SIDES];
  logic [DATA_W-1:0] dat_v   [SIDES];
  logic [DATA_W-1:0] ctl_v   [SIDES];
  logic [SIDES-1:0]  c1_in, c2_in, c2_out, c2_oe, irq, fset;
  logic [DATA_W-1:0] ctrl_a, ctrl_b;
  logic              set_a;

  assign pin_in[0] = port_a_i;
  assign pin_in[1] = port_b_i;
  assign c1_in     = {ctl1_b_i, ctl1_a_i};
  assign c2_in     = {ctl2_b_i, ctl2_a_i};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam logic SIDE = 1'(s);
    logic hit;
    assign hit = cs_i && (rsel_i[1] == SIDE);

    par_io_side #(.SYNC_STAGES(SYNC_STAGES)) u_side (
      .clk_i, .rst_ni,
      .wr_dat_i  (hit && wr_i && !rsel_i[0]),
      .wr_ctl_i  (hit && wr_i &&  rsel_i[0]),
      .rd_dat_i  (hit && rd_i && !rsel_i[0]),
      .wdata_i,
      .dat_view_o(dat_v[s]),
      .ctl_view_o(ctl_v[s]),
      .pin_i     (pin_in[s]),
      .pin_o     (pin_out[s]),
      .pin_oe_o  (pin_oe[s]),
      .c1_i      (c1_in[s]),
      .c2_i      (c2_in[s]),
      .c2_o      (c2_out[s]),
      .c2_oe_o   (c2_oe[s]),
      .irq_o     (irq[s]),
      .flag_set_o(fset[s])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (cs_i && rd_i) begin
      unique case (rsel_i)
        2'd0:    rdata_o = dat_v[0];
        2'd1:    rdata_o = ctl_v[0];
        2'd2:    rdata_o = dat_v[1];
        default: rdata_o = ctl_v[1];
      endcase
    end
  end

  assign irq_a_o     = irq[0];
  assign irq_b_o     = irq[1];
  assign port_a_o    = pin_out[0];
  assign port_a_oe_o = pin_oe[0];
  assign port_b_o    = pin_out[1];
  assign port_b_oe_o = pin_oe[1];
  assign ctl2_a_o    = c2_out[0];
  assign ctl2_a_oe_o = c2_oe[0];
  assign ctl2_b_o    = c2_out[1];
  assign ctl2_b_oe_o = c2_oe[1];
  assign ctrl_a      = ctl_v[0];
  assign ctrl_b      = ctl_v[1];
  assign set_a       = fset[0];
endmodule

// File: rtl/par_io_checker.sv
module par_io_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_i,
  input logic       rd_i,
  input logic       wr_i,
  input logic [1:0] rsel_i,
  input logic [7:0] wdata_i,
  input logic       irq_a_o,
  input logic [7:0] port_a_oe_o,
  input logic       ctl2_b_o,
  input logic [7:0] ctrl_a,
  input logic [7:0] ctrl_b,
  input logic       set_a
);
  a_r7_data_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && rsel_i == 2'd0 && ctrl_a[2] && !set_a)
      |=> (!irq_a_o && ctrl_a[7:6] == 2'b00));

  a_r8_flags_not_writable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && rsel_i == 2'd1 && !set_a && ctrl_a[7:6] == 2'b00)
      |=> (ctrl_a[7:6] == 2'b00));

  a_r2_ddr_write_drives_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && rsel_i == 2'd0 && !ctrl_a[2])
      |=> (port_a_oe_o == $past(wdata_i)));

  a_r9_strobe_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_b[5:4] == 2'b10 && !ctl2_b_o)
      |-> $past(cs_i && wr_i && rsel_i == 2'd2 && ctrl_b[2]));

  a_r6_irq_has_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_a_o |-> (ctrl_a[7] || ctrl_a[6]));
endmodule

bind par_io_adapter par_io_checker u_chk (.*);

// File: tb/par_io_adapter_test.sv
module par_io_adapter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_i = 0, wr_i = 0, rd_i = 0;
  logic [1:0] rsel_i = 0;
  logic [7:0] wdata_i = 0;
  logic [7:0] rdata_o;
  logic       irq_a_o, irq_b_o;
  logic [7:0] port_a_i = 0, port_a_o, port_a_oe_o;
  logic [7:0] port_b_i = 0, port_b_o, port_b_oe_o;
  logic       ctl1_a_i = 0, ctl2_a_i = 0, ctl2_a_o, ctl2_a_oe_o;
  logic       ctl1_b_i = 0, ctl2_b_i = 0, ctl2_b_o, ctl2_b_oe_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_io_adapter uut (
    .clk_i(clk), .rst_ni, .cs_i, .rsel_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
    .irq_a_o, .irq_b_o,
    .port_a_i, .port_a_o, .port_a_oe_o, .ctl1_a_i, .ctl2_a_i, .ctl2_a_o, .ctl2_a_oe_o,
    .port_b_i, .port_b_o, .port_b_oe_o, .ctl1_b_i, .ctl2_b_i, .ctl2_b_o, .ctl2_b_oe_o
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_i = 1; wr_i = 1; rsel_i = a; wdata_i = d;
    @(negedge clk);
    cs_i = 0; wr_i = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_i = 1; rd_i = 1; rsel_i = a;
    #1 d = rdata_o;
    @(negedge clk);
    cs_i = 0; rd_i = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      bus_rd(2'(a), d);
      check("R1 reg read", d, 8'h00);
    end
    check("R1 oe a", port_a_oe_o, 8'h00);
    check("R1 oe b", port_b_oe_o, 8'h00);
    check("R1 irq", {6'd0, irq_b_o, irq_a_o}, 8'h00);
    check("R1 c2 oe", {6'd0, ctl2_b_oe_o, ctl2_a_oe_o}, 8'h00);
  endtask

  task automatic t_ports();
    logic [7:0] d;
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd0, 8'hF0);
    check("R2 oe follows ddr", port_a_oe_o, 8'hF0);
    bus_rd(2'd0, d);
    check("R3 ddr readback", d, 8'hF0);
    bus_wr(2'd1, 8'h04);
    bus_wr(2'd0, 8'h5A);
    check("R3 data reg drives port", port_a_o, 8'h5A);
    check("R3 ddr untouched", port_a_oe_o, 8'hF0);
    port_a_i = 8'h33;
    bus_rd(2'd0, d);
    check("R4 mixed read", d, 8'h53);
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd0, 8'hFF);
    bus_wr(2'd1, 8'h04);
    bus_rd(2'd0, d);
    check("R4 all outputs read", d, 8'h5A);
    check("R12 side b oe", port_b_oe_o, 8'h00);
  endtask

  task automatic t_c1_edges();
    logic [7:0] d;
    bus_wr(2'd1, 8'hC7);
    bus_rd(2'd1, d);
    check("R8 flags read only", d, 8'h07);
    @(negedge clk); ctl1_a_i = 1;
    @(negedge clk); @(negedge clk);
    check("R5 latency before flag", {7'd0, irq_a_o}, 8'h00);
    @(negedge clk);
    check("R5 rising edge irq", {7'd0, irq_a_o}, 8'h01);
    bus_rd(2'd1, d);
    check("R5 flag bit7", d, 8'h87);
    check("R12 other side quiet", {7'd0, irq_b_o}, 8'h00);
    bus_wr(2'd1, 8'hC3);
    bus_rd(2'd1, d);
    check("R7 ctrl write keeps flag", d, 8'h83);
    bus_rd(2'd0, d);
    bus_rd(2'd1, d);
    check("R7 ddr read keeps flag", d, 8'h83);
    bus_wr(2'd1, 8'h07);
    bus_rd(2'd0, d);
    check("R7 irq cleared", {7'd0, irq_a_o}, 8'h00);
    bus_rd(2'd1, d);
    check("R7 flags cleared", d, 8'h07);
    @(negedge clk); ctl1_a_i = 0;
    settle();
    bus_rd(2'd1, d);
    check("R5 opposite edge ignored", d, 8'h07);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    bus_wr(2'd1, 8'h06);
    @(negedge clk); ctl1_a_i = 1;
    settle();
    check("R6 masked irq", {7'd0, irq_a_o}, 8'h00);
    bus_rd(2'd1, d);
    check("R6 masked flag visible", d, 8'h86);
    bus_wr(2'd1, 8'h07);
    check("R6 enable raises irq", {7'd0, irq_a_o}, 8'h01);
    bus_rd(2'd0, d);
    @(negedge clk); ctl1_a_i = 0;
    settle();
    check("R7 clean after clear", {7'd0, irq_a_o}, 8'h00);
  endtask

  task automatic t_strobe();
    logic [7:0] d;
    bus_wr(2'd3, 8'hED);
    bus_rd(2'd3, d);
    check("R8 b ctrl readback", d, 8'h2D);
    check("R9 c2 oe", {7'd0, ctl2_b_oe_o}, 8'h01);
    check("R9 c2 idle high", {7'd0, ctl2_b_o}, 8'h01);
    bus_wr(2'd2, 8'h41);
    check("R9 strobe low", {7'd0, ctl2_b_o}, 8'h00);
    check("R3 b data out", port_b_o, 8'h41);
    @(negedge clk);
    check("R9 strobe one clock", {7'd0, ctl2_b_o}, 8'h01);
    bus_wr(2'd3, 8'h29);
    bus_wr(2'd2, 8'hFF);
    check("R9 no pulse on ddr write", {7'd0, ctl2_b_o}, 8'h01);
    @(negedge clk);
    check("R9 still high", {7'd0, ctl2_b_o}, 8'h01);
    check("R2 b oe", port_b_oe_o, 8'hFF);
    bus_wr(2'd3, 8'hED);
    @(negedge clk); ctl1_b_i = 1;
    settle();
    bus_rd(2'd3, d);
    check("R5 b rising ignored", d, 8'h2D);
    @(negedge clk); ctl1_b_i = 0;
    settle();
    check("R5 b falling irq", {7'd0, irq_b_o}, 8'h01);
    check("R12 a untouched", {7'd0, irq_a_o}, 8'h00);
    bus_rd(2'd3, d);
    check("R5 b flag", d, 8'hAD);
    bus_rd(2'd2, d);
    check("R7 b irq cleared", {7'd0, irq_b_o}, 8'h00);
  endtask

  task automatic t_level();
    bus_wr(2'd3, 8'h30);
    check("R10 level low", {6'd0, ctl2_b_oe_o, ctl2_b_o}, 8'h02);
    bus_wr(2'd3, 8'h38);
    check("R10 level high", {6'd0, ctl2_b_oe_o, ctl2_b_o}, 8'h03);
  endtask

  task automatic t_c2_input();
    logic [7:0] d;
    bus_wr(2'd1, 8'h1C);
    check("R11 c2 input oe", {7'd0, ctl2_a_oe_o}, 8'h00);
    @(negedge clk); ctl2_a_i = 1;
    settle();
    check("R11 c2 irq", {7'd0, irq_a_o}, 8'h01);
    bus_rd(2'd1, d);
    check("R11 c2 flag bit6", d, 8'h5C);
    bus_rd(2'd0, d);
    bus_rd(2'd1, d);
    check("R7 bit6 cleared", d, 8'h1C);
    @(negedge clk); ctl2_a_i = 0;
    settle();
    bus_rd(2'd1, d);
    check("R11 falling ignored", d, 8'h1C);
    bus_wr(2'd1, 8'h0C);
    @(negedge clk); ctl2_a_i = 1;
    settle();
    @(negedge clk); ctl2_a_i = 0;
    settle();
    bus_rd(2'd1, d);
    check("R11 falling selected", d, 8'h4C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_ports();
    t_c1_edges();
    t_mask();
    t_strobe();
    t_level();
    t_c2_input();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule